// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block sits between the result port of an analog-to-digital converter and the FIFO that collects sequencer results. At the start of every sequencer step it clears a flip-flop accumulator, captures the averaging factor, and asks the converter for samples. Every accepted sample of that step's channel is added to the accumulator. After the last sample the block emits one averaged 12-bit word with a single-cycle valid strobe. The averaging covers back-to-back conversions inside one step and never spans separate triggers. Each step therefore yields exactly one FIFO entry, and throughput drops by the chosen factor.

Only power-of-two factors are supported, up to 64. The division is a fixed bit-select of the accumulator, so no divider is built. The result truncates toward zero. A single factor setting is shared by every sequencer that feeds the block. That setting is captured when a step starts, so a change made while a step is running applies to the next step.

Top module: `oversample_avg`

## Requirements
- R1: `avg_sel` selects the number of samples per step as 2 raised to the code: code 0 means 1 sample, codes 1 to 6 mean 2, 4, 8, 16, 32 and 64 samples, and code 7 is treated as 64.
- R2: A `step_start` pulse clears the accumulator and starts a step. `smp_req` is high from the cycle after the pulse until the cycle after the last sample of the step is accepted.
- R3: The accumulator is 18 bits wide. Sixty-four samples of 4095 average to exactly 4095 with no wrap.
- R4: The result equals the sum of the step's samples divided by the sample count, truncated toward zero. For example, four samples of 3413 followed by four of 2048 at code 3 give 2730.
- R5: Each completed step produces exactly one `avg_valid` pulse, one cycle wide, in the cycle after the last sample is accepted. No pulse appears for intermediate samples, and `smp_req` is low while the pulse is high.
- R6: A `smp_valid` that arrives while no step is active is ignored. It produces no output and does not change the next step's result.
- R7: The factor code is captured on `step_start`. Changing `avg_sel` during a step does not change that step's sample count or result.
- R8: A `step_start` during an active step discards the partial sum and begins a new step. A sample presented in the same cycle as `step_start` is dropped.
- R9: At code 0 (bypass), each step outputs its single sample unchanged.
- R10: After reset, `avg_valid`, `smp_req` and `avg_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_start | input | 1 | One-cycle pulse that begins a sequencer step |
| avg_sel | input | 3 | Averaging factor code (log2 of the sample count) |
| smp_valid | input | 1 | A converter sample is present on `smp_data` |
| smp_data | input | 12 | Converter sample |
| smp_req | output | 1 | Block is waiting for more samples of the current step |
| avg_valid | output | 1 | One-cycle strobe that marks an averaged result |
| avg_data | output | 12 | Averaged result; holds its value until the next strobe |

## Verification
The bench builds the block with its default parameters: 12-bit samples and a maximum shift of 6. This brings every factor from bypass to 64 into reach, along with the full 18-bit accumulator range needed by a 64-sample full-scale step. Idle gaps between samples show that the strobe waits for the last accepted sample, not for a fixed cycle count. Directed cases cover the mixed-level midpoint, a mid-step factor change, a restart partway through a step, and stray samples between steps.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int OVS_SMP_W    = 12;
    localparam int OVS_MAX_LOG2 = 6;

endpackage

// File: rtl/ovs_factor_decode.sv
module ovs_factor_decode #(
    parameter int MAX_LOG2 = ovs_pkg::OVS_MAX_LOG2,
    parameter int CODE_W   = 3,
    localparam int SH_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [SH_W-1:0]   shift
);

    // Codes beyond the largest supported factor saturate to it.
    always_comb begin
        if (int'(code) > MAX_LOG2) begin
            shift = SH_W'(MAX_LOG2);
        end else begin
            shift = SH_W'(code);
        end
    end

endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
    parameter int SMP_W = ovs_pkg::OVS_SMP_W,
    parameter int ACC_W = ovs_pkg::OVS_SMP_W + ovs_pkg::OVS_MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [SMP_W-1:0] add_val,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] sum_nxt
);

    logic [ACC_W-1:0] acc_d;

    always_comb begin
        sum_nxt = acc_q + ACC_W'(add_val);
        if (clr) begin
            acc_d = '0;
        end else if (add_en) begin
            acc_d = sum_nxt;
        end else begin
            acc_d = acc_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R2: a step start leaves an empty accumulator behind
    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

endmodule

// File: rtl/ovs_shift_sel.sv
module ovs_shift_sel #(
    parameter int SMP_W    = ovs_pkg::OVS_SMP_W,
    parameter int MAX_LOG2 = ovs_pkg::OVS_MAX_LOG2,
    localparam int ACC_W   = SMP_W + MAX_LOG2,
    localparam int SH_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]  shift,
    output logic [SMP_W-1:0] res
);

    logic [SMP_W-1:0] taps [MAX_LOG2+1];

    // Each tap is the accumulator seen through one fixed right shift.
    for (genvar k = 0; k <= MAX_LOG2; k++) begin : g_tap
        assign taps[k] = acc[k +: SMP_W];
    end

    always_comb begin
        res = '0;
        for (int k = 0; k <= MAX_LOG2; k++) begin
            if (int'(shift) == k) begin
                res = taps[k];
            end
        end
    end

endmodule

// File: rtl/oversample_avg.sv
module oversample_avg #(
    parameter int SMP_W    = ovs_pkg::OVS_SMP_W,
    parameter int MAX_LOG2 = ovs_pkg::OVS_MAX_LOG2,
    parameter int CODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_start,
    input  logic [CODE_W-1:0] avg_sel,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              smp_req,
    output logic              avg_valid,
    output logic [SMP_W-1:0]  avg_data
);

    localparam int ACC_W = SMP_W + MAX_LOG2;
    localparam int SH_W  = $clog2(MAX_LOG2 + 1);
    localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;
    localparam int FULL  = (1 << SMP_W) - 1;

    typedef struct packed {
        logic             active;
        logic [SH_W-1:0]  shift;
        logic [CNT_W-1:0] cnt;
        logic             out_vld;
        logic [SMP_W-1:0] out_dat;
    } st_t;

    st_t st_d, st_q;

    logic [SH_W-1:0]  dec_shift;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_nxt;
    logic [SMP_W-1:0] avg_w;
    logic [CNT_W-1:0] last_idx;
    logic             accept;

    ovs_factor_decode #(
        .MAX_LOG2 (MAX_LOG2),
        .CODE_W   (CODE_W)
    ) u_dec (
        .code  (avg_sel),
        .shift (dec_shift)
    );

    ovs_accum #(
        .SMP_W (SMP_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step_start),
        .add_en  (accept),
        .add_val (smp_data),
        .acc_q   (acc_q),
        .sum_nxt (sum_nxt)
    );

    ovs_shift_sel #(
        .SMP_W    (SMP_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_sel (
        .acc   (sum_nxt),
        .shift (st_q.shift),
        .res   (avg_w)
    );

    always_comb begin
        last_idx = CNT_W'((1 << st_q.shift) - 1);
        accept   = st_q.active && smp_valid && !step_start;

        st_d         = st_q;
        st_d.out_vld = 1'b0;

        if (step_start) begin
            st_d.active = 1'b1;
            st_d.shift  = dec_shift;
            st_d.cnt    = '0;
        end else if (accept) begin
            if (st_q.cnt == last_idx) begin
                st_d.active  = 1'b0;
                st_d.cnt     = '0;
                st_d.out_vld = 1'b1;
                st_d.out_dat = avg_w;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_req   = st_q.active;
    assign avg_valid = st_q.out_vld;
    assign avg_data  = st_q.out_dat;

    // R5: the result strobe is a single cycle wide
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> !avg_valid);

    // R5: no further samples are requested while a result is presented
    p_no_req_with_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> !smp_req);

    // R2: a step start always opens the sample request
    p_req_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_start |=> smp_req);

    // R6: with no request open and no start, no result can appear
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_req && !step_start) |=> !avg_valid);

    // R3: the partial sum never exceeds accepted samples times full scale
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (int'(acc_q) <= int'(st_q.cnt) * FULL));

endmodule

// File: tb/oversample_avg_bench.sv
module oversample_avg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_start = 1'b0;
    logic [2:0]  avg_sel = 3'd0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = 12'd0;
    logic        smp_req;
    logic        avg_valid;
    logic [11:0] avg_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    oversample_avg u_oversample_avg (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_start (step_start),
        .avg_sel    (avg_sel),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .smp_req    (smp_req),
        .avg_valid  (avg_valid),
        .avg_data   (avg_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int smp_of(input int mode, input int i, input int n);
        case (mode)
            0:       return 4095;
            1:       return (i * 523 + 97) % 4096;
            2:       return (i < n / 2) ? 3413 : 2048;
            default: return 10;
        endcase
    endfunction

    // Runs one step, optionally changing avg_sel after the start pulse.
    task automatic run_step(input int code, input int code_mid, input int n,
                            input int mode, input string req);
        int sum = 0;
        int early = 0;
        @(negedge clk);
        avg_sel = 3'(code);
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        avg_sel = 3'(code_mid);
        chk(smp_req == 1'b1, "R2 request open", int'(smp_req), 1);
        for (int i = 0; i < n; i++) begin
            if (i % 3 == 2) begin
                @(negedge clk);
                if (avg_valid) early++;
            end
            smp_valid = 1'b1;
            smp_data = 12'(smp_of(mode, i, n));
            sum += smp_of(mode, i, n);
            @(negedge clk);
            smp_valid = 1'b0;
            if (i < n - 1 && (avg_valid || !smp_req)) early++;
        end
        chk(avg_valid == 1'b1, {req, " strobe"}, int'(avg_valid), 1);
        chk(int'(avg_data) == sum / n, {req, " value"}, int'(avg_data), sum / n);
        chk(early == 0, "R5 no early strobe", early, 0);
        @(negedge clk);
        chk(!avg_valid && !smp_req, "R5 strobe ends, request closed",
            int'({avg_valid, smp_req}), 0);
    endtask

    task automatic t_reset;
        chk(!avg_valid && !smp_req && avg_data == 12'd0, "R10 reset state",
            int'({avg_valid, smp_req}) + int'(avg_data), 0);
    endtask

    task automatic t_bypass;
        run_step(0, 0, 1, 1, "R9 bypass");
        run_step(0, 0, 1, 0, "R9 bypass full");
    endtask

    task automatic t_factors;
        for (int c = 1; c <= 6; c++) run_step(c, c, 1 << c, 1, "R1 R4 factor");
        run_step(7, 7, 64, 1, "R1 code7");
    endtask

    task automatic t_fullscale;
        run_step(6, 6, 64, 0, "R3 full scale");
    endtask

    task automatic t_mixed;
        run_step(3, 3, 8, 2, "R4 midpoint");
        chk(avg_data == 12'd2730, "R4 midpoint code", int'(avg_data), 2730);
    endtask

    task automatic t_idle;
        int seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data = 12'd4095;
            @(negedge clk);
            smp_valid = 1'b0;
            if (avg_valid) seen++;
        end
        chk(seen == 0, "R6 idle samples ignored", seen, 0);
        run_step(1, 1, 2, 3, "R6 next step clean");
    endtask

    task automatic t_midchange;
        run_step(2, 0, 4, 1, "R7 factor held");
        run_step(0, 5, 1, 1, "R7 factor held bypass");
    endtask

    task automatic t_restart;
        int early = 0;
        @(negedge clk);
        avg_sel = 3'd3;
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            smp_valid = 1'b1;
            smp_data = 12'd4095;
            @(negedge clk);
        end
        smp_valid = 1'b1;
        smp_data = 12'd4095;
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            smp_valid = 1'b1;
            smp_data = 12'd10;
            @(negedge clk);
            if (i < 7 && avg_valid) early++;
        end
        smp_valid = 1'b0;
        chk(avg_valid == 1'b1, "R8 restart strobe", int'(avg_valid), 1);
        chk(avg_data == 12'd10, "R8 partial sum discarded", int'(avg_data), 10);
        chk(early == 0, "R8 no early strobe", early, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bypass();
        t_factors();
        t_fullscale();
        t_mixed();
        t_idle();
        t_midchange();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule